// File: doc/BRIEF.md
# Integer Execute Unit with Immediate Operands

This block is the integer execute stage of a 32-bit load/store processor. Each cycle it takes a decoded operation code, two register operands with the register indices they were read from, a 16-bit immediate and a 5-bit shift amount. It returns a 32-bit result, a signed-overflow flag and a flag saying whether operand B came from the extended immediate rather than from the register.

How the immediate is widened depends on the operation class. Arithmetic, compare and address forms sign-extend it. Bitwise forms zero-extend it. Load-upper places it in the top half of the result. There is no subtract-with-immediate and no NOR-with-immediate. A subtract by a constant is written as add-immediate with a negative constant.

Operands whose register index is 0 are forced to zero on entry. All outputs are registered, so a result appears one clock after its inputs are presented. Fetch, register storage, memory access and trap delivery belong to other blocks. Overflow is reported only as a flag.

Top module: `exu_core`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o`, `ovf_o` and `bsel_imm_o` are all zero after that edge.
- R2: Outputs follow the inputs presented before a rising edge, one cycle later. `bsel_imm_o` is 1 exactly for operation codes 16 to 24 (immediate forms) and 0 for codes 0 to 15.
- R3: For codes 16 (ADDI), 17 (ADDIU), 18 (SLTI), 19 (SLTIU) and 24 (ADDR, address sum), operand B is the immediate sign-extended from bit 15. For codes 20 (ANDI), 21 (ORI) and 22 (XORI), it is the immediate with bits 31:16 zero.
- R4: Code 23 (LUI) yields the immediate in bits 31:16 and zero in bits 15:0, whatever the values of A and B.
- R5: Codes 8 (SLT) and 18 (SLTI) compare A and B as two's complement values. Codes 9 (SLTU) and 19 (SLTIU) compare them as unsigned magnitudes. The result is exactly 1 when A is less than B and 0 otherwise.
- R6: Codes 4 (AND), 5 (OR), 6 (XOR) and 7 (NOR) combine A and B bitwise across all 32 bits.
- R7: Codes 10 (SLL), 11 (SRL) and 12 (SRA) shift B left logically, right logically or right arithmetically by `shamt_i`. Codes 13, 14 and 15 do the same shifts by A[4:0].
- R8: `ovf_o` is 1 only for codes 0 (ADD), 2 (SUB) and 16 (ADDI), and only when the operand signs allow overflow and the result sign differs from A. All other codes, including 1 (ADDU), 3 (SUBU), 17 and 24, give 0.
- R9: When `a_idx_i` or `b_idx_i` is 0, the matching operand is treated as zero regardless of `a_data_i` or `b_data_i`.
- R10: Codes 0, 1, 16, 17 and 24 give A+B, and codes 2 and 3 give A-B, both modulo 2^32. Codes 25 to 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Decoded operation code |
| a_idx_i | input | 5 | Register index operand A was read from |
| a_data_i | input | 32 | Register value for operand A |
| b_idx_i | input | 5 | Register index operand B was read from |
| b_data_i | input | 32 | Register value for operand B |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed-overflow flag |
| bsel_imm_o | output | 1 | Registered flag: operand B was the extended immediate |

## Verification
The only state in the block is the output register stage, so any wrong internal value shows up at `result_o` or `ovf_o` one edge after the offending operation. A wrong extension choice shows in the top half of the result: ones where zeros belong after ANDI, or a positive sum where ADDI with a negative constant should give a negative one. A wrong compare shows as a 0/1 swap or as set bits above bit 0. Because no state carries over between operations, each directed case is checked on the very next cycle. A stuck or mis-selected path is therefore caught by the first case that uses it.

// File: rtl/exu_pkg.sv
package exu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_SLL   = 5'd10,
    OP_SRL   = 5'd11,
    OP_SRA   = 5'd12,
    OP_SLLV  = 5'd13,
    OP_SRLV  = 5'd14,
    OP_SRAV  = 5'd15,
    OP_ADDI  = 5'd16,
    OP_ADDIU = 5'd17,
    OP_SLTI  = 5'd18,
    OP_SLTIU = 5'd19,
    OP_ANDI  = 5'd20,
    OP_ORI   = 5'd21,
    OP_XORI  = 5'd22,
    OP_LUI   = 5'd23,
    OP_ADDR  = 5'd24
  } exu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN = 2'd0,
    EXT_ZERO = 2'd1,
    EXT_HIGH = 2'd2
  } ext_mode_e;

  typedef enum logic [1:0] {
    SH_LL = 2'd0,
    SH_RL = 2'd1,
    SH_RA = 2'd2
  } shift_kind_e;

  typedef struct packed {
    logic        use_imm;
    ext_mode_e   ext;
    logic        sub;
    logic        ovf_en;
    logic        var_shift;
    shift_kind_e sh_kind;
  } exu_ctrl_t;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [4:0] op_i,
  output exu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.ext       = EXT_SIGN;
    ctrl_o.sh_kind   = SH_LL;
    ctrl_o.use_imm   = op_i[4] && (op_i <= 5'd24);
    unique case (op_i)
      OP_ADD:   ctrl_o.ovf_en = 1'b1;
      OP_SUB:   begin ctrl_o.sub = 1'b1; ctrl_o.ovf_en = 1'b1; end
      OP_SUBU:  ctrl_o.sub = 1'b1;
      OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU: ctrl_o.sub = 1'b1;
      OP_SRL:   ctrl_o.sh_kind = SH_RL;
      OP_SRA:   ctrl_o.sh_kind = SH_RA;
      OP_SLLV:  ctrl_o.var_shift = 1'b1;
      OP_SRLV:  begin ctrl_o.var_shift = 1'b1; ctrl_o.sh_kind = SH_RL; end
      OP_SRAV:  begin ctrl_o.var_shift = 1'b1; ctrl_o.sh_kind = SH_RA; end
      OP_ADDI:  ctrl_o.ovf_en = 1'b1;
      OP_ANDI, OP_ORI, OP_XORI: ctrl_o.ext = EXT_ZERO;
      OP_LUI:   ctrl_o.ext = EXT_HIGH;
      default:  ;
    endcase
  end

endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [XLEN-1:0]  a_data_i,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic [XLEN-1:0]  b_data_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  ext_mode_e        ext_i,
  output logic [XLEN-1:0]  opa_o,
  output logic [XLEN-1:0]  opb_o,
  output logic [XLEN-1:0]  imm_ext_o
);

  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] rb;

  assign opa_o = (a_idx_i == '0) ? '0 : a_data_i;
  assign rb    = (b_idx_i == '0) ? '0 : b_data_i;

  always_comb begin
    unique case (ext_i)
      EXT_ZERO: imm_ext_o = {{PAD_W{1'b0}}, imm_i};
      EXT_HIGH: imm_ext_o = {imm_i, {PAD_W{1'b0}}};
      default:  imm_ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end

  assign opb_o = use_imm_i ? imm_ext_o : rb;

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);

  logic [XLEN:0]   wide;
  logic [XLEN-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o = wide[XLEN-1:0];

  // signed overflow: effective operands agree in sign, result does not
  assign ovf_o  = (a_i[XLEN-1] == b_eff[XLEN-1]) && (sum_o[XLEN-1] != a_i[XLEN-1]);
  // no carry out of a - b means a borrow, i.e. a < b unsigned
  assign lt_u_o = ~wide[XLEN];
  assign lt_s_o = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : sum_o[XLEN-1];

endmodule

// File: rtl/exu_shift.sv
module exu_shift
  import exu_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] val_i,
  input  logic [SH_W-1:0] amt_i,
  input  shift_kind_e     kind_i,
  output logic [XLEN-1:0] res_o
);

  logic            left;
  logic            fill;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] stage [SH_W+1];

  assign left = (kind_i == SH_LL);
  assign fill = (kind_i == SH_RA) ? val_i[XLEN-1] : 1'b0;

  // left shift done as a right shift of the bit-reversed value
  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      src[i] = left ? val_i[XLEN-1-i] : val_i[i];
    end
  end

  assign stage[0] = src;

  genvar k;
  generate
    for (k = 0; k < SH_W; k++) begin : g_stage
      localparam int D = 1 << k;
      assign stage[k+1] = amt_i[k] ? {{D{fill}}, stage[k][XLEN-1:D]} : stage[k];
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      res_o[i] = left ? stage[SH_W][XLEN-1-i] : stage[SH_W][i];
    end
  end

endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [4:0]       op_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [XLEN-1:0]  a_data_i,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic [XLEN-1:0]  b_data_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [XLEN-1:0]  result_o,
  output logic             ovf_o,
  output logic             bsel_imm_o
);

  exu_ctrl_t       ctrl;
  logic [XLEN-1:0] opa, opb, imm_ext;
  logic [XLEN-1:0] sum, sh_res;
  logic            ovf_raw, lt_s, lt_u;
  logic [SH_W-1:0] sh_amt;
  logic [XLEN-1:0] res_d;

  exu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  exu_operand #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_opnd (
    .a_idx_i   (a_idx_i),
    .a_data_i  (a_data_i),
    .b_idx_i   (b_idx_i),
    .b_data_i  (b_data_i),
    .imm_i     (imm_i),
    .use_imm_i (ctrl.use_imm),
    .ext_i     (ctrl.ext),
    .opa_o     (opa),
    .opb_o     (opb),
    .imm_ext_o (imm_ext)
  );

  exu_addsub #(.XLEN(XLEN)) u_add (
    .a_i    (opa),
    .b_i    (opb),
    .sub_i  (ctrl.sub),
    .sum_o  (sum),
    .ovf_o  (ovf_raw),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  assign sh_amt = ctrl.var_shift ? opa[SH_W-1:0] : shamt_i;

  exu_shift #(.XLEN(XLEN)) u_sh (
    .val_i  (opb),
    .amt_i  (sh_amt),
    .kind_i (ctrl.sh_kind),
    .res_o  (sh_res)
  );

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
      OP_ADDI, OP_ADDIU, OP_ADDR:          res_d = sum;
      OP_AND, OP_ANDI:                     res_d = opa & opb;
      OP_OR,  OP_ORI:                      res_d = opa | opb;
      OP_XOR, OP_XORI:                     res_d = opa ^ opb;
      OP_NOR:                              res_d = ~(opa | opb);
      OP_SLT, OP_SLTI:                     res_d = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU, OP_SLTIU:                   res_d = {{(XLEN-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA,
      OP_SLLV, OP_SRLV, OP_SRAV:           res_d = sh_res;
      OP_LUI:                              res_d = imm_ext;
      default:                             res_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o   <= '0;
      ovf_o      <= 1'b0;
      bsel_imm_o <= 1'b0;
    end else begin
      result_o   <= res_d;
      ovf_o      <= ctrl.ovf_en & ovf_raw;
      bsel_imm_o <= ctrl.use_imm;
    end
  end

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  parameter int IDX_W = 5,
  localparam int SH_W = $clog2(XLEN)
) (
  input logic             clk,
  input logic             rst,
  input logic [4:0]       op_i,
  input logic [IMM_W-1:0] imm_i,
  input logic [XLEN-1:0]  result_o,
  input logic             ovf_o,
  input logic             bsel_imm_o
);

  AST_BSEL_CLASS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bsel_imm_o == ($past(op_i) >= 5'd16 && $past(op_i) <= 5'd24))); // R2

  AST_ANDI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd20) |=> (result_o[XLEN-1:IMM_W] == '0)); // R3

  AST_LUI_FORM: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd23) |=> (result_o == {$past(imm_i), {(XLEN-IMM_W){1'b0}}})); // R4

  AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (rst)
    (op_i == 5'd8 || op_i == 5'd9 || op_i == 5'd18 || op_i == 5'd19)
      |=> (result_o[XLEN-1:1] == '0)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !(op_i == 5'd0 || op_i == 5'd2 || op_i == 5'd16) |=> !ovf_o); // R8

endmodule

bind exu_core exu_core_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .imm_i      (imm_i),
  .result_o   (result_o),
  .ovf_o      (ovf_o),
  .bsel_imm_o (bsel_imm_o)
);

// File: tb/sim_exu_core.sv
`timescale 1ns/1ps
module sim_exu_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_i = '0;
  logic [4:0]  a_idx_i = '0;
  logic [31:0] a_data_i = '0;
  logic [4:0]  b_idx_i = '0;
  logic [31:0] b_data_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  shamt_i = '0;
  logic [31:0] result_o;
  logic        ovf_o;
  logic        bsel_imm_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exu_core u0 (
    .clk(clk), .rst(rst), .op_i(op_i),
    .a_idx_i(a_idx_i), .a_data_i(a_data_i),
    .b_idx_i(b_idx_i), .b_data_i(b_data_i),
    .imm_i(imm_i), .shamt_i(shamt_i),
    .result_o(result_o), .ovf_o(ovf_o), .bsel_imm_o(bsel_imm_o)
  );

  // Present inputs at a falling edge; the result is registered at the next
  // rising edge and sampled at the falling edge after it.
  task automatic run_op(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input logic [4:0] sh);
    @(negedge clk);
    op_i = op; a_idx_i = 5'd3; a_data_i = a; b_idx_i = 5'd4; b_data_i = b;
    imm_i = imm; shamt_i = sh;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [31:0] er, input logic eo, input logic eb);
    checks++;
    if (result_o !== er || ovf_o !== eo || bsel_imm_o !== eb) begin
      failures++;
      $display("FAIL %s: result=%h ovf=%b bsel=%b expected result=%h ovf=%b bsel=%b",
               req, result_o, ovf_o, bsel_imm_o, er, eo, eb);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    op_i = 5'd7; a_data_i = '0; b_data_i = '0;
    rst = 1'b1;
    @(negedge clk);
    expect_out("R1 reset clears outputs", 32'h0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_addsub();
    run_op(5'd0, 32'd1000, 32'd2000, 16'h0, 5'd0);
    expect_out("R10 ADD", 32'd3000, 1'b0, 1'b0);
    run_op(5'd3, 32'd5, 32'd7, 16'h0, 5'd0);
    expect_out("R10 SUBU wrap", 32'hFFFF_FFFE, 1'b0, 1'b0);
    run_op(5'd1, 32'hFFFF_FFFF, 32'd2, 16'h0, 5'd0);
    expect_out("R10 ADDU wrap", 32'd1, 1'b0, 1'b0);
    run_op(5'd27, 32'h1234, 32'h5678, 16'hFFFF, 5'd3);
    expect_out("R10 unused code", 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_imm_ext();
    run_op(5'd16, 32'd10, 32'hDEAD_BEEF, 16'hFFC4, 5'd0);
    expect_out("R3 ADDI negative constant", 32'hFFFF_FFCE, 1'b0, 1'b1);
    run_op(5'd24, 32'h0000_1000, 32'h0, 16'hFFFC, 5'd0);
    expect_out("R3 ADDR sign-extended", 32'h0000_0FFC, 1'b0, 1'b1);
    run_op(5'd20, 32'hFFFF_FFFF, 32'h0, 16'h8723, 5'd0);
    expect_out("R3 ANDI zero-extended", 32'h0000_8723, 1'b0, 1'b1);
    run_op(5'd21, 32'h0000_0000, 32'hFFFF_FFFF, 16'hABCD, 5'd0);
    expect_out("R3 ORI zero-extended", 32'h0000_ABCD, 1'b0, 1'b1);
    run_op(5'd22, 32'h1234_5678, 32'h0, 16'hFF12, 5'd0);
    expect_out("R3 XORI zero-extended", 32'h1234_A96A, 1'b0, 1'b1);
  endtask

  task automatic t_lui();
    run_op(5'd23, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h5678, 5'd7);
    expect_out("R4 LUI", 32'h5678_0000, 1'b0, 1'b1);
    run_op(5'd21, 32'h5678_0000, 32'h0, 16'hABCD, 5'd0);
    expect_out("R4 LUI then ORI", 32'h5678_ABCD, 1'b0, 1'b1);
  endtask

  task automatic t_slt();
    run_op(5'd8, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    expect_out("R5 SLT signed true", 32'd1, 1'b0, 1'b0);
    run_op(5'd9, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);
    expect_out("R5 SLTU unsigned false", 32'd0, 1'b0, 1'b0);
    run_op(5'd8, 32'd9, 32'd9, 16'h0, 5'd0);
    expect_out("R5 SLT equal", 32'd0, 1'b0, 1'b0);
    run_op(5'd18, 32'hFFFF_FFFB, 32'h0, 16'hFFFF, 5'd0);
    expect_out("R5 SLTI -5 < -1", 32'd1, 1'b0, 1'b1);
    run_op(5'd19, 32'd5, 32'h0, 16'hFFFF, 5'd0);
    expect_out("R5 SLTIU 5 < 0xFFFFFFFF", 32'd1, 1'b0, 1'b1);
    run_op(5'd8, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 5'd0);
    expect_out("R5 SLT extreme operands", 32'd1, 1'b0, 1'b0);
  endtask

  task automatic t_logic();
    run_op(5'd4, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 5'd0);
    expect_out("R6 AND", 32'hF000_1200, 1'b0, 1'b0);
    run_op(5'd5, 32'hF0F0_0000, 32'h0F00_000F, 16'h0, 5'd0);
    expect_out("R6 OR", 32'hFFF0_000F, 1'b0, 1'b0);
    run_op(5'd6, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0, 5'd0);
    expect_out("R6 XOR", 32'h5555_AAAA, 1'b0, 1'b0);
    run_op(5'd7, 32'h0000_00F0, 32'h0F00_0000, 16'hFFFF, 5'd0);
    expect_out("R6 NOR", 32'hF0FF_FF0F, 1'b0, 1'b0);
  endtask

  task automatic t_shift();
    run_op(5'd10, 32'h0, 32'd1, 16'h0, 5'd31);
    expect_out("R7 SLL 31", 32'h8000_0000, 1'b0, 1'b0);
    run_op(5'd11, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
    expect_out("R7 SRL 4", 32'h0800_0000, 1'b0, 1'b0);
    run_op(5'd12, 32'h0, 32'h8000_0000, 16'h0, 5'd4);
    expect_out("R7 SRA 4", 32'hF800_0000, 1'b0, 1'b0);
    run_op(5'd13, 32'h0000_0023, 32'd1, 16'h0, 5'd0);
    expect_out("R7 SLLV by A[4:0]=3", 32'd8, 1'b0, 1'b0);
    run_op(5'd15, 32'hFFFF_FFE8, 32'h8000_0010, 16'h0, 5'd1);
    expect_out("R7 SRAV by A[4:0]=8", 32'hFF80_0000, 1'b0, 1'b0);
    run_op(5'd14, 32'h0000_0000, 32'h8765_4321, 16'h0, 5'd9);
    expect_out("R7 SRLV by zero", 32'h8765_4321, 1'b0, 1'b0);
  endtask

  task automatic t_ovf();
    run_op(5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);
    expect_out("R8 ADD overflow", 32'h8000_0000, 1'b1, 1'b0);
    run_op(5'd1, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);
    expect_out("R8 ADDU no flag", 32'h8000_0000, 1'b0, 1'b0);
    run_op(5'd2, 32'h8000_0000, 32'd1, 16'h0, 5'd0);
    expect_out("R8 SUB overflow", 32'h7FFF_FFFF, 1'b1, 1'b0);
    run_op(5'd2, 32'h0000_0005, 32'hFFFF_FFFF, 16'h0, 5'd0);
    expect_out("R8 SUB mixed signs no overflow", 32'd6, 1'b0, 1'b0);
    run_op(5'd16, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
    expect_out("R8 ADDI negative overflow", 32'h7FFF_FFFF, 1'b1, 1'b1);
    run_op(5'd17, 32'h8000_0000, 32'h0, 16'hFFFF, 5'd0);
    expect_out("R8 ADDIU no flag", 32'h7FFF_FFFF, 1'b0, 1'b1);
  endtask

  task automatic t_zero_idx();
    @(negedge clk);
    op_i = 5'd0; a_idx_i = 5'd0; a_data_i = 32'd123; b_idx_i = 5'd4; b_data_i = 32'd5;
    @(negedge clk);
    expect_out("R9 index 0 on A", 32'd5, 1'b0, 1'b0);
    op_i = 5'd5; a_idx_i = 5'd2; a_data_i = 32'h0000_0F00; b_idx_i = 5'd0; b_data_i = 32'hFFFF_FFFF;
    @(negedge clk);
    expect_out("R9 index 0 on B", 32'h0000_0F00, 1'b0, 1'b0);
    op_i = 5'd16; a_idx_i = 5'd0; a_data_i = 32'hFFFF_FFFF; imm_i = 16'd1234;
    @(negedge clk);
    expect_out("R9 index 0 with immediate", 32'd1234, 1'b0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_addsub();
    t_imm_ext();
    t_lui();
    t_slt();
    t_logic();
    t_shift();
    t_ovf();
    t_zero_idx();
    // R1 again: reset after activity clears the registered outputs
    run_op(5'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);
    t_reset();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
    end
  end

endmodule